// File: doc/BRIEF.md
# Four-Way Pairwise-Age Replacement Tracker

This block tracks the relative age of the four entries of a small, fully associative translation buffer and names the entry to overwrite on the next refill. The age information is a six-bit pairwise-ordering matrix. Each bit records, for one pair of entries, which of the two was used less recently. The matrix sits in a six-bit field at the top of a 32-bit control register. The block owns this register. A hit can rewrite only the age field. A software write replaces the whole register.

On every hit the client presents the 2-bit index of the entry that matched. The block then marks that entry as more recent than each of the other three. The replacement index is decoded at all times from the stored matrix, so a refill can use it in the same cycle. If software has loaded a matrix that describes no consistent ordering, the block still names entry 0 and raises a flag.

Top module: `plru4_tracker`

## Requirements
- R1: After synchronous reset the whole register reads zero, the victim index is 3, and the bad-state flag is low.
- R2: A hit on entry 0 clears age bits A5, A4 and A3 and keeps A2, A1 and A0. Age bit An is register bit LRU_LSB+n, and the default is LRU_LSB=26.
- R3: A hit on entry 1 sets A5, clears A2 and A1, and keeps A4, A3 and A0.
- R4: A hit on entry 2 sets A4 and A2, clears A0, and keeps A5, A3 and A1.
- R5: A hit on entry 3 sets A3, A1 and A0 and keeps A5, A4 and A2.
- R6: A hit never changes any register bit outside the age field.
- R7: The victim index is decoded combinationally from the stored age field. It is 0 when A5=A4=A3=1, 1 when A5=0 and A2=A1=1, 2 when A4=0, A2=0 and A0=1, and 3 when A3=0, A1=0 and A0=0. After a hit on entry 1, 2 or 3, that entry is not the victim.
- R8: When the age field matches none of the R7 patterns (for example A5..A0 = 000010), the victim index is 0 and the bad-state flag is high. Otherwise the flag is low.
- R9: A software write loads all register bits from the write data on the next clock edge. If a hit arrives in the same cycle, the hit is ignored.
- R10: With neither a hit nor a write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A lookup hit occurred this cycle |
| hit_way | input | 2 | Index of the entry that hit |
| cfg_wr | input | 1 | Software write strobe for the whole register |
| cfg_wdata | input | REG_W (32) | Software write data |
| cfg_rdata | output | REG_W (32) | Current register contents |
| victim_way | output | 2 | Entry to replace on the next refill |
| state_bad | output | 1 | Age field matches no valid ordering |

## Verification
The bench builds the block with its defaults: a 32-bit register with the age field at bits 31:26. This setup puts non-zero bits both below and around the field, so a hit that leaks outside the field is caught. A reference model keeps an explicit "older-than" relation for each pair of entries and is compared with the block on every clock. Directed runs cover every hit from reset, a loaded inconsistent matrix and its recovery through hits, and a write colliding with a hit. Random runs then reach all reachable orderings together with random writes.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

    localparam int WAYS     = 4;
    localparam int AGE_BITS = 6;

    typedef logic [1:0]          way_t;
    typedef logic [AGE_BITS-1:0] age_t;

    typedef struct packed {
        logic valid;
        way_t way;
    } hit_t;

    typedef struct packed {
        way_t way;
        logic bad;
    } pick_t;

    // Mark one entry newer than all three others.
    function automatic age_t age_touch(age_t s, way_t w);
        age_t n;
        n = s;
        case (w)
            2'd0: begin
                n[5] = 1'b0; n[4] = 1'b0; n[3] = 1'b0;
            end
            2'd1: begin
                n[5] = 1'b1; n[2] = 1'b0; n[1] = 1'b0;
            end
            2'd2: begin
                n[4] = 1'b1; n[2] = 1'b1; n[0] = 1'b0;
            end
            default: begin
                n[3] = 1'b1; n[1] = 1'b1; n[0] = 1'b1;
            end
        endcase
        return n;
    endfunction

    // Per-entry "oldest of all" match vector.
    function automatic logic [WAYS-1:0] age_oldest(age_t s);
        logic [WAYS-1:0] m;
        m[0] =  s[5] &  s[4] &  s[3];
        m[1] = ~s[5] &  s[2] &  s[1];
        m[2] = ~s[4] & ~s[2] &  s[0];
        m[3] = ~s[3] & ~s[1] & ~s[0];
        return m;
    endfunction

endpackage

// File: rtl/plru4_next.sv
module plru4_next
    import plru4_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int LRU_LSB = 26
) (
    input  logic [REG_W-1:0] cur,
    input  hit_t             hit,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] nxt
);
    localparam int LRU_MSB = LRU_LSB + AGE_BITS - 1;

    always_comb begin
        nxt = cur;
        if (wr) begin
            nxt = wdata;
        end else if (hit.valid) begin
            nxt[LRU_MSB:LRU_LSB] = age_touch(cur[LRU_MSB:LRU_LSB], hit.way);
        end
    end
endmodule

// File: rtl/plru4_pick.sv
module plru4_pick
    import plru4_pkg::*;
(
    input  age_t  age,
    output pick_t pick
);
    logic [WAYS-1:0] match;

    always_comb begin
        match     = age_oldest(age);
        pick.way  = 2'd0;
        pick.bad  = (match == '0);
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (match[k]) begin
                pick.way = way_t'(k);
            end
        end
    end
endmodule

// File: rtl/plru4_tracker.sv
module plru4_tracker
    import plru4_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int LRU_LSB = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [1:0]       hit_way,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [1:0]       victim_way,
    output logic             state_bad
);
    localparam int LRU_MSB = LRU_LSB + AGE_BITS - 1;

    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_d;
    hit_t             hit;
    pick_t            pick;

    assign hit.valid = hit_valid;
    assign hit.way   = hit_way;

    plru4_next #(.REG_W(REG_W), .LRU_LSB(LRU_LSB)) u_next (
        .cur   (reg_q),
        .hit   (hit),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .nxt   (reg_d)
    );

    plru4_pick u_pick (
        .age  (reg_q[LRU_MSB:LRU_LSB]),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign cfg_rdata  = reg_q;
    assign victim_way = pick.way;
    assign state_bad  = pick.bad;
endmodule

// File: rtl/plru4_tracker_chk.sv
module plru4_tracker_chk #(
    parameter int REG_W   = 32,
    parameter int LRU_LSB = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_valid,
    input logic [1:0]       hit_way,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic [1:0]       victim_way,
    input logic             state_bad
);
    localparam int A = LRU_LSB;

    p_hit0_r2: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !cfg_wr && hit_way == 2'd0) |=>
        (cfg_rdata[A+5:A+3] == 3'b000 && cfg_rdata[A+2:A] == $past(cfg_rdata[A+2:A])));

    p_hit3_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !cfg_wr && hit_way == 2'd3) |=>
        (cfg_rdata[A+3] && cfg_rdata[A+1] && cfg_rdata[A]
         && cfg_rdata[A+5:A+4] == $past(cfg_rdata[A+5:A+4])
         && cfg_rdata[A+2] == $past(cfg_rdata[A+2])));

    p_low_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !cfg_wr) |=> (cfg_rdata[A-1:0] == $past(cfg_rdata[A-1:0])));

    p_hit_not_victim_r7: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !cfg_wr && hit_way != 2'd0) |=> (victim_way != $past(hit_way)));

    p_bad_way0_r8: assert property (@(posedge clk) disable iff (rst)
        state_bad |-> (victim_way == 2'd0));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!hit_valid && !cfg_wr) |=> $stable(cfg_rdata));
endmodule

bind plru4_tracker plru4_tracker_chk #(.REG_W(REG_W), .LRU_LSB(LRU_LSB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .victim_way (victim_way),
    .state_bad  (state_bad)
);

// File: tb/test_plru4_tracker.sv
module test_plru4_tracker;
    localparam int REG_W   = 32;
    localparam int LRU_LSB = 26;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hit_valid = 1'b0;
    logic [1:0]       hit_way = 2'd0;
    logic             cfg_wr = 1'b0;
    logic [REG_W-1:0] cfg_wdata = '0;
    logic [REG_W-1:0] cfg_rdata;
    logic [1:0]       victim_way;
    logic             state_bad;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference: full register plus explicit "a older than b" relation.
    logic [REG_W-1:0] m_reg = '0;
    string            last_tag = "R1";

    always #5 clk = ~clk;

    plru4_tracker #(.REG_W(REG_W), .LRU_LSB(LRU_LSB)) i_plru4_tracker (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_way(hit_way),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .victim_way(victim_way), .state_bad(state_bad)
    );

    function automatic int pair_bit(int a, int b);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        if (lo == 0) return LRU_LSB + 6 - hi;
        if (lo == 1) return LRU_LSB + 4 - hi;
        return LRU_LSB + 3 - hi;
    endfunction

    function automatic bit is_older(logic [REG_W-1:0] r, int a, int b);
        if (a < b) return r[pair_bit(a, b)];
        return !r[pair_bit(a, b)];
    endfunction

    function automatic int ref_victim(logic [REG_W-1:0] r);
        for (int k = 0; k < 4; k++) begin
            bit all = 1'b1;
            for (int j = 0; j < 4; j++)
                if (j != k && !is_older(r, k, j)) all = 1'b0;
            if (all) return k;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_reg = '0;
            last_tag = "R1";
        end else if (cfg_wr) begin
            m_reg = cfg_wdata;
            last_tag = "R9";
        end else if (hit_valid) begin
            for (int j = 0; j < 4; j++)
                if (j != hit_way) m_reg[pair_bit(hit_way, j)] = (j > hit_way) ? 1'b0 : 1'b1;
            case (hit_way)
                2'd0: last_tag = "R2";
                2'd1: last_tag = "R3";
                2'd2: last_tag = "R4";
                default: last_tag = "R5";
            endcase
        end else begin
            last_tag = "R10";
        end
    end

    task automatic check(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int v = ref_victim(m_reg);
        check(last_tag, cfg_rdata, m_reg);
        check("R6 low bits", {6'd0, cfg_rdata[LRU_LSB-1:0]}, {6'd0, m_reg[LRU_LSB-1:0]});
        check("R7 victim", REG_W'(victim_way), REG_W'((v < 0) ? 0 : v));
        check("R8 bad flag", REG_W'(state_bad), REG_W'(v < 0));
    endtask

    task automatic step(bit h, logic [1:0] w, bit wr, logic [REG_W-1:0] d);
        hit_valid = h; hit_way = w; cfg_wr = wr; cfg_wdata = d;
        @(negedge clk);
        hit_valid = 1'b0; cfg_wr = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 reg", cfg_rdata, '0);
        check("R1 victim", REG_W'(victim_way), REG_W'(3));
        check("R1 flag", REG_W'(state_bad), '0);
        // Load non-zero low bits, then each hit (R2..R5, R6)
        step(0, 0, 1, 32'h0000_A5C3);
        step(1, 3, 0, '0);
        step(1, 2, 0, '0);
        step(1, 1, 0, '0);
        step(1, 0, 0, '0);
        check("R7 oldest after 3,2,1,0", REG_W'(victim_way), REG_W'(3));
        step(0, 0, 0, '0);
        // R8: inconsistent matrix A=000010 keeping low bits
        step(0, 0, 1, 32'h0800_1234);
        check("R8 bad flag", REG_W'(state_bad), REG_W'(1));
        check("R8 victim", REG_W'(victim_way), REG_W'(0));
        step(1, 3, 0, '0);
        step(1, 1, 0, '0);
        // R9: write collides with hit
        step(1, 0, 1, 32'hFC00_0001);
        check("R9 write wins", cfg_rdata, 32'hFC00_0001);
        // Random mix
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom_range(0, 9);
            step(r < 6 || r == 9, 2'($urandom), r >= 8, $urandom);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule